// File: doc/BRIEF.md
# Stacked-Plane Hit Coincidence Matcher

This block forms trigger primitives for a pair of stacked sensor planes. Each pixel of the lower plane holds its own cleaned hit. It looks at a small window of cleaned hits from the upper plane, around the same position. When its own hit and at least one enabled upper-plane hit in that window are both present, the pixel raises a trigger bit. Such a match marks a track with a small bend, which means high transverse momentum. Every clock cycle produces a fresh decision, registered one cycle after the inputs.

A chip-level mode input selects the chip's role. A decision-making chip drives the trigger outputs. A forwarding chip only passes its cleaned image on through `pass_hits`, and its trigger outputs stay at zero.

Each pixel has a 12-bit configuration word. The word holds an enable bit, a window-shape bit and a 10-bit tap mask. The words are shifted in over a daisy chain that runs from pixel to pixel on its own clock. A separate load strobe, sampled on the main clock, copies the shifted words into the working copies that the logic uses.

Top module: `hitmatch_array`

## Requirements
- R1: Pixel index is p = r*COLS + c, with r the row and c the column. With shape bit 0 (square window), tap k (0..8) looks at the upper pixel at row r + k/3 - 1 and column c + k%3 - 1. The trigger bit is set when the local hit is 1, the pixel is enabled, and any tap whose mask bit is 1 sees an upper hit.
- R2: With shape bit 1 (wide window), tap k (0..9) looks at the upper pixel at row r + k/5 and column c + k%5 - 2. The trigger rule is the same as in R1.
- R3: In the square shape, mask bit 9 has no effect on the trigger bit.
- R4: A tap whose position falls outside the array counts as no hit. A column past the row's end does not wrap to the next row.
- R5: A pixel with no local hit never raises its trigger bit.
- R6: When `is_master` is 0, every trigger bit is 0.
- R7: A pixel whose enable bit (word bit 11) is 0 never raises its trigger bit.
- R8: `trig` reflects the inputs sampled at the previous rising clock edge. It does not change before that edge.
- R9: The configuration word is laid out as bit 11 = enable, bit 10 = shape, bits 9..0 = tap mask (bit k controls tap k). Words are shifted MSB first on rising `cfg_clk`, and the word for pixel ROWS*COLS-1 goes in first. `cfg_dout` shows the bit that entered ROWS*COLS*12 shifts earlier.
- R10: Shifting new bits into the chain does not change the trigger behaviour until `cfg_load` is sampled high on a rising `clk` edge.
- R11: Reset clears `trig` and `pass_hits`. The loaded configuration survives reset.
- R12: `pass_hits` equals `local_hit` registered by one clock, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decision clock |
| rst_n | input | 1 | Asynchronous active-low reset of the decision registers |
| is_master | input | 1 | 1: chip makes trigger decisions; 0: forwarding only |
| local_hit | input | ROWS*COLS | Cleaned hits of this plane, index r*COLS+c |
| upper_hit | input | ROWS*COLS | Cleaned image received from the upper plane |
| cfg_clk | input | 1 | Shift clock of the configuration chain |
| cfg_din | input | 1 | Serial configuration data into pixel 0 |
| cfg_load | input | 1 | Copies the shifted words into the working configuration |
| cfg_dout | output | 1 | Serial configuration data out of the last pixel |
| trig | output | ROWS*COLS | Registered trigger bits |
| pass_hits | output | ROWS*COLS | Registered copy of local_hit, forwarded to the other plane |

## Verification
A table of local/upper hit patterns is replayed under two configurations. The first is a uniform full-mask square setup, which shows whether the neighbourhood geometry is right. The second mixes shapes, masks and disabled pixels, which exposes mask-bit and shape-select errors. Directed patterns place a single upper hit on a chosen tap to tell the square and wide tap mappings apart, put a hit one column across a row end to catch flat-index wrap, and load a mask holding only bit 9 in square shape. Slave mode, shifting without a load, and a mid-run reset followed by use of the old configuration separate the mode, load-strobe and reset-scope behaviour.

// File: rtl/hitmatch_pkg.sv
package hitmatch_pkg;

  localparam int TAPS  = 10;
  localparam int CFG_W = 12;

  typedef struct packed {
    logic             en;
    logic             wide;
    logic [TAPS-1:0]  mask;
  } pix_cfg_t;

  // Row offset of tap k for the chosen window shape
  function automatic int tap_dr(input bit wide, input int k);
    return wide ? (k / 5) : (k / 3 - 1);
  endfunction

  // Column offset of tap k for the chosen window shape
  function automatic int tap_dc(input bit wide, input int k);
    return wide ? (k % 5 - 2) : (k % 3 - 1);
  endfunction

  // Square window uses taps 0..8 only
  function automatic bit tap_used(input bit wide, input int k);
    return wide || (k < 9);
  endfunction

  // Masked OR over the window selected by the shape bit
  function automatic logic window_hit(input pix_cfg_t cfg,
                                      input logic [TAPS-1:0] sq,
                                      input logic [TAPS-1:0] wd);
    logic [TAPS-1:0] sel;
    sel = cfg.wide ? wd : (sq & {1'b0, {(TAPS-1){1'b1}}});
    return |(sel & cfg.mask);
  endfunction

endpackage

// File: rtl/hitmatch_cfg_cell.sv
module hitmatch_cfg_cell
  import hitmatch_pkg::*;
(
  input  logic     cfg_clk,
  input  logic     sin,
  output logic     sout,
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  output pix_cfg_t active
);

  logic [CFG_W-1:0] shadow;

  // Serial stage: bits enter at the LSB, leave at the MSB
  always_ff @(posedge cfg_clk)
    shadow <= {shadow[CFG_W-2:0], sin};

  assign sout = shadow[CFG_W-1];

  // Working copy: not touched by reset, only by the load strobe
  always_ff @(posedge clk)
    if (load) active <= pix_cfg_t'(shadow);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));

endmodule

// File: rtl/hitmatch_pixel.sv
module hitmatch_pixel
  import hitmatch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            local_hit,
  input  logic [TAPS-1:0] sq_taps,
  input  logic [TAPS-1:0] wd_taps,
  input  pix_cfg_t        cfg,
  output logic            trig,
  output logic            pass
);

  logic win_hit;
  logic match_now;

  assign win_hit   = window_hit(cfg, sq_taps, wd_taps);
  assign match_now = is_master & cfg.en & local_hit & win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= 1'b0;
      pass <= 1'b0;
    end else begin
      trig <= match_now;
      pass <= local_hit;
    end
  end

  assert_no_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !local_hit |=> !trig);

  assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !trig);

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !trig);

  assert_pass_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pass == $past(local_hit)));

endmodule

// File: rtl/hitmatch_array.sv
module hitmatch_array
  import hitmatch_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 6,
  localparam int NPIX = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic [NPIX-1:0] local_hit,
  input  logic [NPIX-1:0] upper_hit,
  input  logic            cfg_clk,
  input  logic            cfg_din,
  input  logic            cfg_load,
  output logic            cfg_dout,
  output logic [NPIX-1:0] trig,
  output logic [NPIX-1:0] pass_hits
);

  logic [NPIX:0] chain;
  assign chain[0] = cfg_din;
  assign cfg_dout = chain[NPIX];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r * COLS + c;

      logic [TAPS-1:0] sq;
      logic [TAPS-1:0] wd;
      pix_cfg_t        cfg;

      // Gather the upper-plane image around this position, zero beyond edges
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam int SQR = r + tap_dr(1'b0, k);
        localparam int SQC = c + tap_dc(1'b0, k);
        localparam int WDR = r + tap_dr(1'b1, k);
        localparam int WDC = c + tap_dc(1'b1, k);

        if (tap_used(1'b0, k) && SQR >= 0 && SQR < ROWS && SQC >= 0 && SQC < COLS)
          begin : g_sq_in
          assign sq[k] = upper_hit[SQR*COLS + SQC];
        end else begin : g_sq_out
          assign sq[k] = 1'b0;
        end

        if (WDR >= 0 && WDR < ROWS && WDC >= 0 && WDC < COLS) begin : g_wd_in
          assign wd[k] = upper_hit[WDR*COLS + WDC];
        end else begin : g_wd_out
          assign wd[k] = 1'b0;
        end
      end

      hitmatch_cfg_cell u_cfg (
        .cfg_clk (cfg_clk),
        .sin     (chain[P]),
        .sout    (chain[P+1]),
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .active  (cfg)
      );

      hitmatch_pixel u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .local_hit (local_hit[P]),
        .sq_taps   (sq),
        .wd_taps   (wd),
        .cfg       (cfg),
        .trig      (trig[P]),
        .pass      (pass_hits[P])
      );
    end
  end

  assert_trig_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trig & ~$past(local_hit)) == '0));

endmodule

// File: tb/hitmatch_array_tb.sv
`timescale 1ns/100ps
module hitmatch_array_tb;

  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int N    = ROWS * COLS;
  localparam int W    = 12;
  localparam int NV   = 8;

  localparam logic [N-1:0] VEC_LOC [NV] = '{
    24'h000001, 24'hFFFFFF, 24'hFFFFFF, 24'h0F0F0F,
    24'h123456, 24'hA5A5A5, 24'h800000, 24'hFFFFFF };
  localparam logic [N-1:0] VEC_UP  [NV] = '{
    24'h000002, 24'h000000, 24'h000040, 24'hF0F0F0,
    24'h654321, 24'h5A5A5A, 24'h400000, 24'hFFFFFF };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic [N-1:0] local_hit = '0;
  logic [N-1:0] upper_hit = '0;
  logic cfg_clk = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_load = 1'b0;
  logic cfg_dout;
  logic [N-1:0] trig;
  logic [N-1:0] pass_hits;

  int checks = 0;
  int fails  = 0;

  // bench-side configuration image
  logic        c_en   [N];
  logic        c_wide [N];
  logic [9:0]  c_mask [N];

  always #2.5 clk = ~clk;

  hitmatch_array #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .local_hit(local_hit), .upper_hit(upper_hit),
    .cfg_clk(cfg_clk), .cfg_din(cfg_din), .cfg_load(cfg_load),
    .cfg_dout(cfg_dout), .trig(trig), .pass_hits(pass_hits));

  task automatic check(input bit ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: walk every upper pixel, map its offset back to a tap
  function automatic logic [N-1:0] model(input logic [N-1:0] loc,
                                         input logic [N-1:0] up,
                                         input logic master);
    logic [N-1:0] res = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int p = r*COLS + c;
        if (master && c_en[p] && loc[p])
          for (int r2 = 0; r2 < ROWS; r2++)
            for (int c2 = 0; c2 < COLS; c2++) begin
              int dr = r2 - r;
              int dc = c2 - c;
              int k = -1;
              if (c_wide[p]) begin
                if (dr >= 0 && dr <= 1 && dc >= -2 && dc <= 2) k = dr*5 + dc + 2;
              end else if (dr >= -1 && dr <= 1 && dc >= -1 && dc <= 1)
                k = (dr+1)*3 + dc + 1;
              if (k >= 0 && c_mask[p][k] && up[r2*COLS+c2]) res[p] = 1'b1;
            end
      end
    return res;
  endfunction

  function automatic logic [W-1:0] word_of(input int p);
    return {c_en[p], c_wide[p], c_mask[p]};
  endfunction

  task automatic shift_bit(input logic b);
    cfg_din = b;
    #3 cfg_clk = 1'b1;
    #3 cfg_clk = 1'b0;
    #1;
  endtask

  task automatic load_cfg();
    for (int p = N-1; p >= 0; p--)
      for (int b = W-1; b >= 0; b--)
        shift_bit(word_of(p)[b]);
    @(negedge clk) cfg_load = 1'b1;
    @(negedge clk) cfg_load = 1'b0;
  endtask

  task automatic set_cfg_a();
    for (int p = 0; p < N; p++) begin
      c_en[p] = 1'b1; c_wide[p] = 1'b0; c_mask[p] = 10'h3FF;
    end
  endtask

  task automatic set_cfg_b();
    for (int p = 0; p < N; p++) begin
      c_en[p]   = (p % 5) != 4;
      c_wide[p] = p[0];
      c_mask[p] = (p % 3 == 0) ? 10'h3FF : 10'((p*149 + 85) & 10'h3FF);
    end
  endtask

  task automatic set_cfg_c();
    set_cfg_a();
    c_wide[8]  = 1'b1; c_mask[8]  = 10'h200;  // wide, only tap 9 (row+1, col+2)
    c_mask[9]  = 10'h200;                     // square, only bit 9
    c_en[15]   = 1'b0;                        // disabled
    c_mask[13] = 10'h001;                     // square, only tap 0 (row-1, col-1)
  endtask

  logic [N-1:0] prev_exp = '0;

  task automatic apply(input logic [N-1:0] loc, input logic [N-1:0] up,
                       input string req, input bit chk_hold);
    logic [N-1:0] exp;
    @(negedge clk);
    local_hit = loc; upper_hit = up;
    #1;
    if (chk_hold) check(trig == prev_exp, "R8 output held before edge", trig, prev_exp);
    exp = model(loc, up, is_master);
    @(negedge clk);
    check(trig == exp, req, trig, exp);
    check(pass_hits == loc, "R12 pass_hits", pass_hits, loc);
    prev_exp = exp;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    repeat (3) @(negedge clk);
    check(trig == '0, "R11 reset trig", trig, '0);
    check(pass_hits == '0, "R11 reset pass_hits", pass_hits, '0);
    rst_n = 1'b1;

    // R1 table under uniform square configuration
    set_cfg_a(); load_cfg();
    @(negedge clk); local_hit = '0; upper_hit = '0;
    @(negedge clk); prev_exp = '0;
    for (int i = 0; i < NV; i++) apply(VEC_LOC[i], VEC_UP[i], "R1 table cfgA", 1'b1);

    // R2/R7 table under mixed configuration
    set_cfg_b(); load_cfg();
    prev_exp = model(local_hit, upper_hit, 1'b1);
    for (int i = 0; i < NV; i++) apply(VEC_LOC[i], VEC_UP[i], "R2 R7 table cfgB", 1'b1);

    // R9: chain output replays the last pixel's word, MSB first
    got = '0;
    for (int b = W-1; b >= 0; b--) begin
      got[b] = cfg_dout;
      shift_bit(1'b0);
    end
    check(got == word_of(N-1), "R9 cfg_dout order", N'(got), N'(word_of(N-1)));

    // R10: shifted-in zeros without a load change nothing
    apply(24'hFFFFFF, 24'hFFFFFF, "R10 shift without load", 1'b0);
    apply(24'h0F0F0F, 24'hF0F0F0, "R10 shift without load", 1'b0);

    // Directed tap tests
    set_cfg_c(); load_cfg();
    apply(24'h000100, 24'h010000, "R2 wide tap9 hit", 1'b0);
    check(trig[8] == 1'b1, "R2 pixel8 set", trig, model(24'h000100, 24'h010000, 1'b1));
    apply(24'h000100, 24'h000010, "R2 wide no hit below", 1'b0);
    check(trig[8] == 1'b0, "R2 pixel8 clear", trig, '0);
    apply(24'h002000, 24'h000040, "R1 square tap0", 1'b0);
    check(trig[13] == 1'b1, "R1 pixel13 set", trig, model(24'h002000, 24'h000040, 1'b1));
    apply(24'h000200, 24'hFFFFFF, "R3 square ignores bit9", 1'b0);
    check(trig[9] == 1'b0, "R3 pixel9 clear", trig, '0);
    apply(24'h008000, 24'hFFFFFF, "R7 disabled pixel", 1'b0);
    check(trig[15] == 1'b0, "R7 pixel15 clear", trig, '0);
    apply(24'h000000, 24'hFFFFFF, "R5 no local hit", 1'b0);
    check(trig == '0, "R5 all clear", trig, '0);

    // R4 edges: no wrap across row end
    set_cfg_a(); load_cfg();
    apply(24'h000040, 24'h000020, "R4 no wrap", 1'b0);
    check(trig[6] == 1'b0, "R4 pixel6 clear", trig, '0);
    apply(24'h000040, 24'h000001, "R4 in-array neighbour", 1'b0);
    check(trig[6] == 1'b1, "R4 pixel6 set", trig, 24'h000040);
    apply(24'h800001, 24'hFFFFFF, "R4 corners", 1'b0);

    // R6 slave mode
    is_master = 1'b0;
    apply(24'hFFFFFF, 24'hFFFFFF, "R6 slave quiet", 1'b0);
    check(trig == '0, "R6 all clear", trig, '0);
    is_master = 1'b1;

    // R11 reset keeps configuration
    set_cfg_b(); load_cfg();
    apply(24'hFFFFFF, 24'hFFFFFF, "R11 before reset", 1'b0);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(trig == '0, "R11 trig cleared", trig, '0);
    check(pass_hits == '0, "R11 pass cleared", pass_hits, '0);
    @(negedge clk) rst_n = 1'b1;
    apply(24'h123456, 24'h654321, "R11 config retained", 1'b0);
    apply(24'hFFFFFF, 24'hFFFFFF, "R11 config retained", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule